// File: doc/BRIEF.md
# I2C Slave Address Decoder with Register Readback

This block is the bus-facing front end of a small converter-style peripheral that sits on a two-wire I2C bus as a slave. It oversamples SCL and SDA with the system clock and finds START, repeated START and STOP conditions. After every START, it shifts in one address byte. It compares that byte against a 7-bit slave address built from three parts: a fixed four-bit device code, a two-bit field chosen at build time, and one bit read from a live pin.

When the address matches, the block pulls SDA low for the acknowledge bit, then acts on the direction bit. On a write, each later byte is acknowledged and handed to a command port as a one-cycle pulse, with the first byte flagged as the command-type byte. On a read, the block captures a snapshot of the working data register and its non-volatile copy at the acknowledge. It then shifts that snapshot out byte by byte until the master answers with a NAK or starts over. SDA is driven only as an open-drain pull-down through an enable.

Top module: `i2c_dac_addr_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) or repeated START makes the next eight SCL-rising-edge samples the address byte, most significant bit first, whatever state the block was in.
- R2: The block acknowledges the address byte by driving `sda_oe` high for the ninth clock when address bits [7:1] equal {4'b1100, ADDR_HI2, `a0_pin`}. Bit 0 is the direction bit: 1 means read and 0 means write.
- R3: On an address mismatch the block leaves `sda_oe` low for the acknowledge and for every later bit, and raises no `cmd_valid`, until the next START.
- R4: In a write transaction every byte after the address is acknowledged and presented once on `cmd_data` with a one-cycle `cmd_valid`. `cmd_first` is 1 only for the first byte after the address.
- R5: In a read transaction the block sends bytes MSB first: the bytes of `live_reg`, most significant byte first, then the bytes of `nv_reg` in the same order, and then wraps back to the first byte.
- R6: The read data is captured when the address is acknowledged. Input changes after that point do not alter the bytes sent in that transaction.
- R7: During a read, a master ACK (SDA low on the ninth clock) continues the stream. A NAK (SDA high) makes the block release SDA and stay silent until the next START.
- R8: A repeated START in the middle of a write or a read begins a new address phase, and the following transfer uses the new direction.
- R9: A STOP (SDA rising while SCL is high) returns the block to idle with `sda_oe` low.
- R10: `sda_oe` changes only while SCL is low. Received bits are taken on the SCL rising edge.
- R11: After reset `sda_oe` and `cmd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| a0_pin | input | 1 | Live level that sets the lowest address bit |
| live_reg | input | 8*REG_BYTES | Working data register returned first on a read |
| nv_reg | input | 8*NV_BYTES | Non-volatile copy returned after the working register |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| cmd_valid | output | 1 | One-cycle pulse per received write byte |
| cmd_data | output | 8 | Received write byte |
| cmd_first | output | 1 | Marks the command-type byte that follows the address |

## Verification
The bench builds the block with ADDR_HI2 set to 2'b10, not the default 2'b00, so an address carrying the default field becomes a real mismatch case. It uses two working-register bytes and three non-volatile bytes. The odd total of five lets reads of up to seven bytes cross the wrap point at a length that is not a power of two. Random transactions toggle the A0 pin and mix matching and non-matching addresses. Directed sequences cover a repeated START inside a write and after a read NAK, and input changes made after the read acknowledge.

// File: rtl/i2c_dac_addr_slave.sv
module i2c_dac_addr_slave #(
  parameter logic [1:0] ADDR_HI2  = 2'b00,
  parameter int         REG_BYTES = 3,
  parameter int         NV_BYTES  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_in,
  input  logic                   sda_in,
  input  logic                   a0_pin,
  input  logic [8*REG_BYTES-1:0] live_reg,
  input  logic [8*NV_BYTES-1:0]  nv_reg,
  output logic                   sda_oe,
  output logic                   cmd_valid,
  output logic [7:0]             cmd_data,
  output logic                   cmd_first
);
  localparam int TOT = REG_BYTES + NV_BYTES;
  localparam int IW  = (TOT > 1) ? $clog2(TOT) : 1;
  localparam logic [IW-1:0] LAST = IW'(TOT - 1);
  localparam logic [3:0] DEV_CODE = 4'b1100;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WR, S_RD, S_SKIP} st_t;
  st_t st;

  logic [1:0] scl_sy, sda_sy;
  logic scl_q, sda_q, scl_s, sda_s;
  assign scl_s = scl_sy[1];
  assign sda_s = sda_sy[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in}; sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_s;               sda_q  <= sda_s;
    end

  logic start_c, stop_c, rise, fall;
  assign start_c = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  assign rise    = scl_s & ~scl_q;
  assign fall    = ~scl_s & scl_q;

  logic [3:0]       cnt;
  logic [6:0]       sh;
  logic             ack_pend, first, is_rd;
  logic [8*TOT-1:0] snap;
  logic [IW-1:0]    idx;
  logic [7:0]       rx_byte, tx_byte;
  logic             addr_hit;

  assign rx_byte  = {sh, sda_s};
  assign addr_hit = rx_byte[7:1] == {DEV_CODE, ADDR_HI2, a0_pin};
  assign tx_byte  = snap[8*(TOT-1-int'(idx)) +: 8];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; ack_pend <= 1'b0; first <= 1'b0;
      is_rd <= 1'b0; snap <= '0; idx <= '0; sda_oe <= 1'b0;
      cmd_valid <= 1'b0; cmd_data <= '0; cmd_first <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      if (start_c) begin
        st <= S_ADDR; cnt <= '0; ack_pend <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; ack_pend <= 1'b0; sda_oe <= 1'b0;
      end else if (rise) begin
        case (st)
          S_ADDR, S_WR:
            if (cnt != 4'd8) begin
              sh  <= rx_byte[6:0];
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7) begin
                if (st == S_WR) begin
                  ack_pend <= 1'b1; cmd_valid <= 1'b1; cmd_data <= rx_byte;
                  cmd_first <= first; first <= 1'b0;
                end else if (addr_hit) begin
                  ack_pend <= 1'b1; is_rd <= rx_byte[0];
                end else begin
                  st <= S_SKIP;
                end
              end
            end else begin
              cnt <= '0; ack_pend <= 1'b0;
              if (st == S_ADDR) begin
                st <= is_rd ? S_RD : S_WR;
                first <= 1'b1; idx <= '0;
                if (is_rd) snap <= {live_reg, nv_reg};
              end
            end
          S_RD:
            if (cnt != 4'd8) cnt <= cnt + 4'd1;
            else if (sda_s) st <= S_IDLE;
            else begin
              cnt <= '0;
              idx <= (idx == LAST) ? '0 : idx + 1'b1;
            end
          default: ;
        endcase
      end else if (fall) begin
        case (st)
          S_RD:         sda_oe <= (cnt != 4'd8) & ~tx_byte[3'd7 - cnt[2:0]];
          S_ADDR, S_WR: sda_oe <= (cnt == 4'd8) & ack_pend;
          default:      sda_oe <= 1'b0;
        endcase
      end
    end

  p_oe_rise_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  p_skip_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_SKIP |-> (!sda_oe && !cmd_valid));
  p_cmd_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(st) == S_WR);
  p_cmd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> !sda_oe);
  p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_RD |-> idx <= LAST);
endmodule

// File: tb/sim_i2c_dac_addr_slave.sv
module sim_i2c_dac_addr_slave;
  localparam logic [1:0] HI2 = 2'b10;
  localparam int RB = 2, NB = 3, TB = RB + NB, Q = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, a0 = 1'b0;
  logic [8*RB-1:0] live = '0;
  logic [8*NB-1:0] nv = '0;
  logic sda_oe, cmd_valid, cmd_first, sda_line;
  logic [7:0] cmd_data;
  assign sda_line = m_sda & ~sda_oe;

  always #5 clk = ~clk;

  i2c_dac_addr_slave #(.ADDR_HI2(HI2), .REG_BYTES(RB), .NV_BYTES(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .a0_pin(a0),
    .live_reg(live), .nv_reg(nv), .sda_oe(sda_oe), .cmd_valid(cmd_valid),
    .cmd_data(cmd_data), .cmd_first(cmd_first));

  int n_chk = 0, n_bad = 0, oe_viol = 0;
  logic oe_prev = 1'b0;
  logic [8:0] capq[$];

  always @(negedge clk) begin
    if (cmd_valid) capq.push_back({cmd_first, cmd_data});
    if (rst_n && sda_oe != oe_prev && m_scl) oe_viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit addr_ok(input logic [6:0] a, input logic pin);
    return a == {4'b1100, HI2, pin};
  endfunction

  function automatic logic [7:0] rd_exp(input logic [8*TB-1:0] s, input int k);
    return s[8*(TB-1-(k % TB)) +: 8];
  endfunction

  task automatic wq; repeat (Q) @(negedge clk); endtask

  task automatic bus_start;
    wq; m_sda = 1'b1; wq; m_scl = 1'b1; wq; m_sda = 1'b0; wq; m_scl = 1'b0;
  endtask

  task automatic bus_stop;
    wq; m_sda = 1'b0; wq; m_scl = 1'b1; wq; m_sda = 1'b1; wq;
  endtask

  task automatic put_bit(input logic b);
    wq; m_sda = b; wq; m_scl = 1'b1; wq; wq; m_scl = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; wq; wq; m_scl = 1'b1; wq; b = sda_line; wq; m_scl = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic get_byte(output logic [7:0] d, input bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(!ack);
  endtask

  task automatic write_txn(input logic [6:0] a, input int n, input bit do_stop);
    bit ack, ok;
    logic [7:0] sent[8];
    capq.delete();
    ok = addr_ok(a, a0);
    bus_start;
    put_byte({a, 1'b0}, ack);
    chk(ack == ok, ok ? "R2 address ack (write)" : "R3 mismatch no ack (write)", 64'(ack), 64'(ok));
    for (int i = 0; i < n; i++) begin
      sent[i] = 8'($urandom);
      put_byte(sent[i], ack);
      chk(ack == ok, "R4 data byte ack", 64'(ack), 64'(ok));
    end
    if (do_stop) begin
      bus_stop;
      chk(sda_oe == 1'b0, "R9 released after stop", 64'(sda_oe), 0);
    end
    chk(capq.size() == (ok ? n : 0), ok ? "R4 byte count" : "R3 no command bytes",
        64'(capq.size()), 64'(ok ? n : 0));
    if (ok && capq.size() == n)
      for (int i = 0; i < n; i++)
        chk(capq[i] == {(i == 0), sent[i]}, "R4 command byte/first flag",
            64'(capq[i]), 64'({(i == 0), sent[i]}));
  endtask

  task automatic read_txn(input logic [6:0] a, input int n, input bit do_stop);
    bit ack, ok;
    logic [7:0] d;
    logic [8*TB-1:0] s;
    s = {live, nv};
    ok = addr_ok(a, a0);
    bus_start;
    put_byte({a, 1'b1}, ack);
    chk(ack == ok, ok ? "R2 address ack (read)" : "R3 mismatch no ack (read)", 64'(ack), 64'(ok));
    if (ok) begin
      live = 16'($urandom); nv = 24'($urandom);
      for (int k = 0; k < n; k++) begin
        get_byte(d, k < n - 1);
        chk(d == rd_exp(s, k), "R5 R6 read byte from snapshot", 64'(d), 64'(rd_exp(s, k)));
      end
      get_byte(d, 1'b0);
      chk(d == 8'hFF, "R7 silent after NAK", 64'(d), 64'hFF);
    end else begin
      get_byte(d, 1'b0);
      chk(d == 8'hFF, "R3 silent after mismatch", 64'(d), 64'hFF);
    end
    if (do_stop) begin
      bus_stop;
      chk(sda_oe == 1'b0, "R9 released after stop", 64'(sda_oe), 0);
    end
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    logic [6:0] ga;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0 && cmd_valid == 1'b0, "R11 reset state", 64'({sda_oe, cmd_valid}), 0);

    a0 = 1'b1;
    write_txn({4'b1100, HI2, 1'b1}, 3, 1'b1);
    write_txn({4'b1100, HI2, 1'b0}, 2, 1'b1);
    write_txn({4'b1100, 2'b00, 1'b1}, 2, 1'b1);
    write_txn({4'b1101, HI2, 1'b1}, 1, 1'b1);

    live = 16'hA55A; nv = 24'h0F_E1_3C;
    read_txn({4'b1100, HI2, 1'b1}, 7, 1'b1);
    a0 = 1'b0;
    read_txn({4'b1100, HI2, 1'b0}, 1, 1'b1);

    // R1 R8: repeated START inside a write, then after a read NAK
    capq.delete();
    ga = {4'b1100, HI2, a0};
    bus_start;
    put_byte({ga, 1'b0}, ack);
    put_byte(8'h3C, ack);
    live = 16'h1234; nv = 24'h56_78_9A;
    bus_start;
    put_byte({ga, 1'b1}, ack);
    chk(ack == 1'b1, "R8 read address after repeated START", 64'(ack), 1);
    get_byte(d, 1'b1);
    chk(d == 8'h12, "R8 first read byte", 64'(d), 64'h12);
    get_byte(d, 1'b0);
    chk(d == 8'h34, "R8 second read byte", 64'(d), 64'h34);
    bus_start;
    put_byte({ga, 1'b0}, ack);
    chk(ack == 1'b1, "R1 address after repeated START", 64'(ack), 1);
    put_byte(8'hC3, ack);
    bus_stop;
    chk(capq.size() == 2, "R8 command count across restarts", 64'(capq.size()), 2);
    if (capq.size() == 2) begin
      chk(capq[0] == 9'h13C, "R8 first segment byte", 64'(capq[0]), 64'h13C);
      chk(capq[1] == 9'h1C3, "R1 new segment first flag", 64'(capq[1]), 64'h1C3);
    end

    // R1: mismatched transfer followed by a START without STOP
    bus_start;
    put_byte({4'b0110, HI2, a0, 1'b0}, ack);
    put_byte(8'h55, ack);
    write_txn({4'b1100, HI2, a0}, 2, 1'b1);

    for (int it = 0; it < 25; it++) begin
      a0 = 1'($urandom);
      live = 16'($urandom); nv = 24'($urandom);
      if ($urandom % 2) ga = {4'b1100, HI2, 1'($urandom)};
      else ga = 7'($urandom);
      if ($urandom % 2) write_txn(ga, 1 + ($urandom % 5), 1'b1);
      else read_txn(ga, 1 + ($urandom % 7), 1'b1);
    end

    chk(oe_viol == 0, "R10 sda_oe changes only with SCL low", 64'(oe_viol), 0);
    finish_run;
  end
endmodule